// File: doc/BRIEF.md
# Per-Line Selectable Input Debounce Filter

This block cleans up external interrupt inputs before they reach the interrupt status logic. Every input line first passes through a two-stage synchronizer. The lowest lines, 16 by default, also have a stability filter. A filtered line changes its output only after the synchronized input has held a new value for a chosen number of tick-enable pulses. The remaining lines pass their synchronized input straight through. A line uses the filter only when its enable bit is set and its sensitivity input marks it level-sensitive. Edge-sensitive or disabled lines bypass the filter.

Software configures the lines through a 32-bit register bus. Each bus word holds four 8-bit line fields. There are three windows onto the same fields. The control view is read-only. A write through the set window ORs bits into the fields. A write through the clear window removes the bits written as one. Writing a one to the restart bit through the set window restarts that line's stability counter. The controller uses this after servicing an interrupt. The restart bit is a command, not stored state, and always reads back as zero. The duration code selects the required count from a fixed table that grows in powers of two.

Top module: `line_debounce_filter`

## Requirements
- R1: Line i's field is bits [(i mod 4)*8 +: 8] of the word at byte offset (i/4)*4 from each window base: view at 0x500, set window at 0x600, clear window at 0x700. A set write ORs the written ones into the field, a clear write clears the bits written as one, and writes to the view change nothing. Addresses outside the view read as zero.
- R2: Within a field, bit 0 is the enable, bit 1 is the restart command and bits 6:4 are the duration code. Bits 2, 3 and 7 are not stored and read as zero.
- R3: Duration codes 1 to 6 require 1, 16, 32, 64, 128 and 256 stable ticks, and code 7 requires 256. With a tick on every cycle, an input step reaches the output of a filtered line 2 + ticks clock edges after it is applied.
- R4: Fields of lines 16 and above ignore writes and read as zero, and those lines output their synchronized input.
- R5: A line that is edge-sensitive (sensitivity input 0) or has the enable clear outputs its synchronized input, whatever its duration code is.
- R6: The restart bit reads as zero. A set-window write with bit 1 of a field set clears that line's count at the clock edge that takes the write, so the full duration must elapse again.
- R7: On an active filtered line the count advances only in cycles with tick_en high and the synchronized input differing from the output. The output takes the input's value at the tick where the count reaches the duration. Whenever the input equals the output, the count restarts, and without a tick the output holds.
- R8: An enabled level-sensitive line with duration code 0 outputs its synchronized input with no added delay.
- R9: Each input passes through two register stages. A bypassed line's output follows its input two clock edges later.
- R10: During reset all fields are zero and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data, four line fields |
| bus_rdata | output | 32 | Read data from the control view |
| line_in | input | 32 | Raw external interrupt lines |
| line_level | input | 32 | Per-line sensitivity, 1 = level |
| tick_en | input | 1 | Count-enable pulse for the filters |
| line_out | output | 32 | Filtered or synchronized lines |

## Verification
The bench measures step latency for several duration codes, including code 7, which must take as long as code 6. An off-by-one in the count compare or a wrong table entry shows up as a latency that is one tick off or badly wrong. It mixes the restart command into a partly counted interval. A design that ignored the command, or restarted it a cycle late, lets the output change early. Long randomized bouncing runs with sparse ticks and mixed sensitivities catch a counter that does not restart on a match, or that counts without a tick. They also catch a filter applied to edge-sensitive lines and stored spare or restart bits that read back as non-zero.

// File: rtl/dbf_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, the per-line configuration type and the
// duration-code decoder for the debounce filter. Assumes 8-bit fields,
// four per 32-bit bus word.
package dbf_pkg;
    localparam int FIELD_W        = 8;
    localparam int LINES_PER_WORD = 4;
    localparam int DATA_W         = FIELD_W * LINES_PER_WORD;
    localparam int CODE_W         = 3;
    localparam int EN_BIT         = 0;
    localparam int RST_BIT        = 1;
    localparam int CODE_LSB       = 4;
    localparam int MAX_TICKS      = 256;
    localparam int CNT_W          = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
    } line_cfg_t;

    // Stable-tick count needed for a duration code; top code saturates.
    function automatic logic [CNT_W-1:0] ticks_for_code(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] t;
        if (code == '0)
            t = '0;
        else if (code == CODE_W'(1))
            t = CNT_W'(1);
        else if (code == '1)
            t = CNT_W'(MAX_TICKS);
        else
            t = CNT_W'(1) << (int'(code) + 2);
        return t;
    endfunction
endpackage

// File: rtl/dbf_sync.sv
`timescale 1ns/1ps
// Module: multi-stage input synchronizer, one flop chain per bit.
// Assumes the inputs are asynchronous to clk and STAGES >= 1.
module dbf_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    // Shift each input through the flop chain; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dbf_regs.sv
`timescale 1ns/1ps
// Module: configuration fields for the filtered lines, behind a read-only
// view window and set/clear write windows. The restart bit is not stored.
// A set write produces a one-cycle restart pulse instead. Assumes
// word-aligned accesses; fields of unfiltered lines do not exist.
module dbf_regs import dbf_pkg::*; #(
    parameter int N_LINES   = 32,
    parameter int N_FILT    = 16,
    parameter int ADDR_W    = 12,
    parameter int VIEW_BASE = 'h500,
    parameter int SET_BASE  = 'h600,
    parameter int CLR_BASE  = 'h700
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output line_cfg_t [N_FILT-1:0] cfg,
    output logic [N_FILT-1:0]      rst_pulse
);
    localparam int SPAN   = (N_LINES / LINES_PER_WORD) * 4;
    localparam int WIDX_W = ADDR_W - 2;

    logic [ADDR_W-1:0] view_off, set_off, clr_off;
    logic              view_hit, set_hit, clr_hit;
    logic              unused_wbits;

    assign view_off = bus_addr - ADDR_W'(VIEW_BASE);
    assign set_off  = bus_addr - ADDR_W'(SET_BASE);
    assign clr_off  = bus_addr - ADDR_W'(CLR_BASE);
    assign view_hit = (view_off < ADDR_W'(SPAN)) && (view_off[1:0] == 2'b00);
    assign set_hit  = bus_wr && (set_off < ADDR_W'(SPAN)) && (set_off[1:0] == 2'b00);
    assign clr_hit  = bus_wr && (clr_off < ADDR_W'(SPAN)) && (clr_off[1:0] == 2'b00);
    assign unused_wbits = ^bus_wdata;

    for (genvar i = 0; i < N_FILT; i++) begin : g_field
        localparam int W   = i / LINES_PER_WORD;
        localparam int LSB = (i % LINES_PER_WORD) * FIELD_W;
        logic [FIELD_W-1:0] fd;
        logic               set_me, clr_me;

        assign fd     = bus_wdata[LSB +: FIELD_W];
        assign set_me = set_hit && (set_off[ADDR_W-1:2] == WIDX_W'(W));
        assign clr_me = clr_hit && (clr_off[ADDR_W-1:2] == WIDX_W'(W));
        assign rst_pulse[i] = set_me && fd[RST_BIT];

        // Apply set (OR) or clear (AND-NOT) writes to this line's field.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[i] <= '0;
            end else if (set_me) begin
                cfg[i].en   <= cfg[i].en | fd[EN_BIT];
                cfg[i].code <= cfg[i].code | fd[CODE_LSB +: CODE_W];
            end else if (clr_me) begin
                cfg[i].en   <= cfg[i].en & ~fd[EN_BIT];
                cfg[i].code <= cfg[i].code & ~fd[CODE_LSB +: CODE_W];
            end
        end
    end

    // Assemble the addressed view word; spare and restart bits stay zero.
    always_comb begin
        bus_rdata = '0;
        if (view_hit) begin
            for (int i = 0; i < N_FILT; i++) begin
                if (view_off[ADDR_W-1:2] == WIDX_W'(i / LINES_PER_WORD)) begin
                    bus_rdata[(i % LINES_PER_WORD) * FIELD_W + EN_BIT] = cfg[i].en;
                    bus_rdata[(i % LINES_PER_WORD) * FIELD_W + CODE_LSB +: CODE_W] = cfg[i].code;
                end
            end
        end
    end
endmodule

// File: rtl/dbf_line.sv
`timescale 1ns/1ps
// Module: stability filter for one line. When active (enabled,
// level-sensitive, non-zero code) the output follows the synchronized
// input only after it has differed for the selected number of ticks.
// Otherwise the output is the synchronized input and the held state tracks
// it. Assumes din is already synchronized to clk.
module dbf_line import dbf_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             level,
    input  line_cfg_t        cfg,
    input  logic             restart,
    input  logic             din,
    output logic             dout,
    output logic [CNT_W-1:0] cnt_o
);
    logic             filt_q;
    logic [CNT_W-1:0] cnt_q, cnt_nxt, target;
    logic             active;

    assign active  = cfg.en && level && (cfg.code != '0);
    assign target  = ticks_for_code(cfg.code);
    assign cnt_nxt = cnt_q + 1'b1;

    // Count stable ticks of a differing input and commit at the target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!active) begin
            filt_q <= din;
            cnt_q  <= '0;
        end else if (restart || (din == filt_q)) begin
            cnt_q  <= '0;
        end else if (tick_en) begin
            if (cnt_nxt >= target) begin
                filt_q <= din;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_nxt;
            end
        end
    end

    assign dout  = active ? filt_q : din;
    assign cnt_o = cnt_q;
endmodule

// File: rtl/line_debounce_filter.sv
`timescale 1ns/1ps
// Module: top of the per-line debounce filter. It synchronizes every input
// line, filters the lowest N_FILT lines under register control and passes
// the others through. Assumes N_LINES and N_FILT are multiples of four and
// N_FILT <= N_LINES.
module line_debounce_filter import dbf_pkg::*; #(
    parameter int N_LINES     = 32,
    parameter int N_FILT      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 12,
    parameter int VIEW_BASE   = 'h500,
    parameter int SET_BASE    = 'h600,
    parameter int CLR_BASE    = 'h700
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [N_LINES-1:0] line_in,
    input  logic [N_LINES-1:0] line_level,
    input  logic               tick_en,
    output logic [N_LINES-1:0] line_out
);
    logic [N_LINES-1:0]           sync_q;
    line_cfg_t [N_FILT-1:0]       cfg;
    logic [N_FILT-1:0]            rst_pulse;
    logic [N_FILT-1:0][CNT_W-1:0] cnt_all;

    dbf_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(line_in), .q(sync_q)
    );

    dbf_regs #(
        .N_LINES(N_LINES), .N_FILT(N_FILT), .ADDR_W(ADDR_W),
        .VIEW_BASE(VIEW_BASE), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg(cfg), .rst_pulse(rst_pulse)
    );

    for (genvar i = 0; i < N_FILT; i++) begin : g_filt
        dbf_line line_i (
            .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
            .level(line_level[i]), .cfg(cfg[i]), .restart(rst_pulse[i]),
            .din(sync_q[i]), .dout(line_out[i]), .cnt_o(cnt_all[i])
        );
    end

    for (genvar i = N_FILT; i < N_LINES; i++) begin : g_pass
        assign line_out[i] = sync_q[i];
    end
endmodule

// File: rtl/line_debounce_filter_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for line_debounce_filter, attached by bind.
// Assumes the default field layout of dbf_pkg.
module line_debounce_filter_chk import dbf_pkg::*; #(
    parameter int N_LINES   = 32,
    parameter int N_FILT    = 16,
    parameter int ADDR_W    = 12,
    parameter int VIEW_BASE = 'h500
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [31:0]                  bus_rdata,
    input logic [N_LINES-1:0]           line_in,
    input logic [N_LINES-1:0]           line_level,
    input logic                         tick_en,
    input logic [N_LINES-1:0]           line_out,
    input logic [N_LINES-1:0]           sync_q,
    input line_cfg_t [N_FILT-1:0]       cfg,
    input logic [N_FILT-1:0]            rst_pulse,
    input logic [N_FILT-1:0][CNT_W-1:0] cnt_all
);
    localparam logic [31:0] RST_MASK   = 32'h0202_0202;
    localparam logic [31:0] SPARE_MASK = 32'h8C8C_8C8C;

    logic [1:0] since_rst;
    logic       upper_view;

    // Count edges since reset so history checks start only once it is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign upper_view = (int'(bus_addr) >= VIEW_BASE + N_FILT) &&
                        (int'(bus_addr) <  VIEW_BASE + N_LINES);

    assert_reset_bit_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & RST_MASK) == '0);

    assert_spare_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & SPARE_MASK) == '0);

    assert_upper_fields_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upper_view |-> (bus_rdata == '0));

    assert_sync_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (sync_q == $past(line_in, 2)));

    for (genvar i = 0; i < N_FILT; i++) begin : g_chk
        logic act;
        assign act = cfg[i].en && line_level[i] && (cfg[i].code != '0);

        assert_count_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_pulse[i]) |-> (cnt_all[i] == '0));

        assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!line_level[i] || !cfg[i].en) |-> (line_out[i] == sync_q[i]));

        assert_code0_direct_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[i].en && line_level[i] && (cfg[i].code == '0)) |-> (line_out[i] == sync_q[i]));

        assert_hold_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (act && $past(act) && !$past(tick_en)) |-> $stable(line_out[i]));
    end
endmodule

bind line_debounce_filter line_debounce_filter_chk #(
    .N_LINES(N_LINES), .N_FILT(N_FILT), .ADDR_W(ADDR_W), .VIEW_BASE(VIEW_BASE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .line_in(line_in), .line_level(line_level), .tick_en(tick_en),
    .line_out(line_out), .sync_q(sync_q), .cfg(cfg), .rst_pulse(rst_pulse),
    .cnt_all(cnt_all)
);

// File: tb/line_debounce_filter_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus
// directed latency, register and restart checks.
module line_debounce_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] line_in = '0;
    logic [31:0] line_level = '0;
    logic        tick_en = 1'b0;
    logic [31:0] line_out;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    line_debounce_filter dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in),
        .line_level(line_level), .tick_en(tick_en), .line_out(line_out)
    );

    // ---------------- reference model ----------------
    int          m_en [16];
    int          m_code [16];
    int          m_cnt [16];
    logic        m_filt [16];
    logic [31:0] m_s1 = '0;
    logic [31:0] m_s2 = '0;
    int          dur_tab [8] = '{0, 1, 16, 32, 64, 128, 256, 256};

    function automatic int win_word(input logic [11:0] a, input int base);
        if (int'(a) >= base && int'(a) < base + 32 && a[1:0] == 2'b00)
            return (int'(a) - base) / 4;
        return -1;
    endfunction

    function automatic logic m_active(input int i);
        return (m_en[i] != 0) && line_level[i] && (m_code[i] != 0);
    endfunction

    function automatic logic [31:0] model_out();
        logic [31:0] e;
        e = m_s2;
        for (int i = 0; i < 16; i++) if (m_active(i)) e[i] = m_filt[i];
        return e;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        logic [31:0] r;
        int w;
        r = '0;
        w = win_word(a, 'h500);
        if (w >= 0 && w < 4) begin
            for (int s = 0; s < 4; s++) begin
                r[s*8]       = (m_en[w*4+s] != 0);
                r[s*8+4 +: 3] = 3'(m_code[w*4+s]);
            end
        end
        return r;
    endfunction

    function automatic string tag_of(input int i);
        if (i >= 16) return "R4";
        if (m_en[i] != 0 && line_level[i] && m_code[i] != 0) return "R7";
        if (m_en[i] != 0 && line_level[i]) return "R8";
        return "R5";
    endfunction

    // Advance the model one clock: filters, synchronizer, then bus writes.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                m_en[i] = 0; m_code[i] = 0; m_cnt[i] = 0; m_filt[i] = 1'b0;
            end
            m_s1 = '0; m_s2 = '0;
        end else begin
            int sw, cw;
            sw = bus_wr ? win_word(bus_addr, 'h600) : -1;
            cw = bus_wr ? win_word(bus_addr, 'h700) : -1;
            for (int i = 0; i < 16; i++) begin
                logic rp;
                rp = (sw == i / 4) && bus_wdata[(i % 4) * 8 + 1];
                if (!m_active(i)) begin
                    m_filt[i] = m_s2[i]; m_cnt[i] = 0;
                end else if (rp || m_s2[i] == m_filt[i]) begin
                    m_cnt[i] = 0;
                end else if (tick_en) begin
                    if (m_cnt[i] + 1 >= dur_tab[m_code[i]]) begin
                        m_filt[i] = m_s2[i]; m_cnt[i] = 0;
                    end else begin
                        m_cnt[i] = m_cnt[i] + 1;
                    end
                end
            end
            m_s2 = m_s1;
            m_s1 = line_in;
            for (int i = 0; i < 16; i++) begin
                logic [7:0] f;
                f = bus_wdata[(i % 4) * 8 +: 8];
                if (sw == i / 4) begin
                    m_en[i]   = m_en[i] | int'(f[0]);
                    m_code[i] = m_code[i] | int'(f[6:4]);
                end else if (cw == i / 4) begin
                    m_en[i]   = m_en[i] & ~int'(f[0]);
                    m_code[i] = m_code[i] & ~int'(f[6:4]) & 7;
                end
            end
        end
    end

    // Compare outputs and read data against the model away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] e, er;
            e  = model_out();
            er = model_read(bus_addr);
            vectors++;
            if (line_out !== e) begin
                miscompares++;
                for (int i = 0; i < 32; i++) begin
                    if (line_out[i] !== e[i]) begin
                        $display("FAIL %s line %0d: got %b expected %b", tag_of(i), i, line_out[i], e[i]);
                        break;
                    end
                end
            end
            vectors++;
            if (bus_rdata !== er) begin
                miscompares++;
                $display("FAIL R1 read 0x%h: got %h expected %h", bus_addr, bus_rdata, er);
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(posedge clk); #1;
        bus_addr = a;
        #1 check(tag, bus_rdata, exp);
    endtask

    task automatic cfg_line(input int i, input int en, input int code);
        logic [11:0] off;
        off = 12'((i / 4) * 4);
        bus_write(12'h700 + off, 32'hFF << ((i % 4) * 8));
        bus_write(12'h600 + off, (32'(en) | (32'(code) << 4)) << ((i % 4) * 8));
    endtask

    // Apply a rising step on one line and count edges until the output follows.
    task automatic measure(input string tag, input int ln, input int exp_n);
        int n;
        n = 0;
        @(posedge clk); #1;
        line_in[ln] = 1'b1;
        while (line_out[ln] !== 1'b1 && n < 400) begin
            @(posedge clk); #1;
            n++;
        end
        check(tag, 32'(n), 32'(exp_n));
        line_in[ln] = 1'b0;
        repeat (300) @(posedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        miscompares++;
        $display("FAIL watchdog expired before the R7 run completed");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        check("R10 outputs in reset", line_out, 32'h0);
        bus_addr = 12'h500;
        #1 check("R10 fields in reset", bus_rdata, 32'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // Register windows and field layout
        bus_write(12'h604, 32'h0000_2100);
        read_check("R1 set window", 12'h504, 32'h0000_2100);
        bus_write(12'h704, 32'h0000_0100);
        read_check("R1 clear window", 12'h504, 32'h0000_2000);
        bus_write(12'h504, 32'hFFFF_FFFF);
        read_check("R1 view write ignored", 12'h504, 32'h0000_2000);
        bus_write(12'h600, 32'h8C8C_8C8C);
        read_check("R2 spare bits not stored", 12'h500, 32'h0);
        bus_write(12'h600, 32'h0202_0202);
        read_check("R6 restart bit reads zero", 12'h500, 32'h0);
        bus_write(12'h610, 32'hFFFF_FFFF);
        read_check("R4 upper field reads zero", 12'h510, 32'h0);
        read_check("R4 upper field reads zero", 12'h51C, 32'h0);
        bus_write(12'h704, 32'hFFFF_FFFF);

        // Step latencies with a tick every cycle
        line_level = 32'hFFFF_FFFF;
        tick_en = 1'b1;
        cfg_line(0, 1, 1); measure("R3 code 1", 0, 3);
        cfg_line(0, 1, 2); measure("R3 code 2", 0, 18);
        cfg_line(0, 1, 3); measure("R3 code 3", 0, 34);
        cfg_line(0, 1, 6); measure("R3 code 6", 0, 258);
        cfg_line(0, 1, 7); measure("R3 code 7", 0, 258);
        cfg_line(0, 1, 0); measure("R8 code 0 direct", 0, 2);
        cfg_line(0, 1, 2);
        line_level[0] = 1'b0;
        measure("R5 edge-sensitive bypass", 0, 2);
        line_level[0] = 1'b1;
        cfg_line(0, 0, 2); measure("R5 disabled bypass", 0, 2);
        measure("R9 R4 unfiltered line", 20, 2);

        // Restart in the middle of a count (code 2 = 16 ticks)
        cfg_line(0, 1, 2);
        @(posedge clk); #1;
        line_in[0] = 1'b1;
        repeat (12) @(posedge clk);
        #1;
        bus_wr = 1'b1; bus_addr = 12'h600; bus_wdata = 32'h0000_0002;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        repeat (15) @(posedge clk);
        #1 check("R6 output still held after restart", 32'(line_out[0]), 32'h0);
        @(posedge clk); #1;
        check("R6 output after full duration", 32'(line_out[0]), 32'h1);
        line_in[0] = 1'b0;
        repeat (40) @(posedge clk);

        // Randomized bouncing, sparse ticks, mixed modes
        void'($urandom(32'd12345));
        for (int i = 0; i < 16; i++) begin
            int c;
            c = (i == 11) ? 5 : (i == 15) ? 7 : (i % 4);
            cfg_line(i, (i == 7) ? 0 : 1, c);
        end
        line_level = 32'hA5F3_6E7D;
        for (int k = 0; k < 5000; k++) begin
            @(posedge clk); #1;
            for (int i = 0; i < 32; i++)
                if ($urandom % 24 == 0) line_in[i] = ~line_in[i];
            tick_en = ($urandom % 3) != 0;
            if (k % 97 == 0) begin
                bus_wr = 1'b1;
                bus_addr = 12'h600 + 12'(4 * ($urandom % 4));
                bus_wdata = 32'h0202_0202;
            end else begin
                bus_wr = 1'b0;
                bus_addr = 12'h500 + 12'(4 * ($urandom % 8));
            end
        end
        bus_wr = 1'b0;
        repeat (4) @(posedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule